// File: doc/BRIEF.md
# Stream-to-Memory Descriptor DMA Engine

This block is the receive half of a DMA channel. It takes a byte stream with an end-of-packet marker and stores the bytes in memory buffers. The buffers are described by a linked list of 16-byte descriptors in the same memory. A buffer closes when it fills up or when a packet ends. The engine then patches the descriptor with the real fill point and the packet-end flag, writes it back, raises interrupt bits, and moves on. It either follows the descriptor's link or, at the end of the list, marks the channel context disabled and halts.

Descriptor layout, as word offsets from the descriptor address:
- +0: link to the next descriptor.
- +4: buffer start.
- +8: control word. Bit 0 marks the end of the list, bit 4 asks for an interrupt, and bit 11 is the packet-end flag that the engine writes back.
- +12: end pointer, one past the last usable byte.

Bytes are packed little-endian into 32-bit writes with byte enables, so buffers may begin and end at any byte address.

The engine is one state machine with these states:
- `ST_IDLE`: after reset.
- `ST_FETCH`: four descriptor reads.
- `ST_FILL`: takes stream bytes.
- `ST_FLUSH`: writes a packed word.
- `ST_WB_FLAGS`, then `ST_WB_END`: descriptor write-back.
- `ST_CTX_RD`, then `ST_CTX_WR`: read-modify-write of the context word.
- `ST_HALT`: end of list.

The transitions are:
- `ST_IDLE` or `ST_HALT` goes to `ST_FETCH` on `start_i`.
- `ST_FETCH` goes to `ST_FILL` after the fourth read.
- `ST_FILL` goes to `ST_FLUSH` when a byte fills lane 3 or closes the buffer. It goes straight to `ST_WB_FLAGS` when the buffer is empty (start equals end).
- `ST_FLUSH` goes back to `ST_FILL`, or on to `ST_WB_FLAGS` if closing.
- `ST_WB_FLAGS` goes to `ST_WB_END`.
- `ST_WB_END` goes to `ST_FETCH` at the link address, or to `ST_CTX_RD` if the end-of-list bit is set.
- `ST_CTX_RD` goes to `ST_CTX_WR`, which goes to `ST_HALT`.

Top module: `strm_wr_dma`

## Requirements
- R1: After reset the engine is idle: `s_ready_o`, `mem_req_o`, `irq_upd_o` and `eol_o` are 0 and `irq_raw_o` is 0.
- R2: After a start, the engine reads the descriptor words at offsets +0, +4, +8, +12 in that order. `s_ready_o` is low whenever a memory request is pending.
- R3: A byte taken at pointer P is written to word address P with bits 1:0 cleared. It goes in lane P[1:0] (data bits 8*lane+7:8*lane) with that lane's byte enable set. Lanes not written keep their memory contents.
- R4: A descriptor takes at most (end - start) bytes and closes as soon as the pointer reaches its end field.
- R5: A byte with `s_eop_i` high closes the descriptor early. The written-back end field (+12) holds the final pointer, and control bit 11 is set in the written-back control word (+8).
- R6: On close, the control word (+8, original bits kept) is written first, then the end field (+12).
- R7: On close, control bit 4 sets raw interrupt bits 0 and 1, and an end-of-packet close sets raw bit 3.
- R8: `irq_upd_o` pulses for one cycle after a close only if that close set a raw bit that was not already set.
- R9: A 1 in `irq_ack_i` clears the matching raw interrupt bit.
- R10: A close on a descriptor without bit 0 set fetches the descriptor at its link field and resumes filling at that descriptor's buffer start.
- R11: A close on a descriptor with bit 0 set reads the context word and writes it back with bit 15 set. The engine then raises `eol_o` and holds `s_ready_o` low, so further stream bytes are ignored.
- R12: A descriptor whose start equals its end closes without taking any byte, and bit 11 stays clear.
- R13: `start_i` is ignored while a transfer is running. From idle or halt it starts a new chain and clears `eol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a chain (from idle or halt only) |
| desc_i | input | ADDR_W | Address of the first descriptor |
| ctx_i | input | ADDR_W | Address of the channel context word |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_eop_i | input | 1 | Byte is the last of a packet |
| s_ready_o | output | 1 | Engine takes the byte this cycle |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned request address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | One-cycle acknowledge that completes the request |
| irq_ack_i | input | 4 | Clear mask for raw interrupt bits |
| irq_raw_o | output | 4 | Raw interrupt bits |
| irq_upd_o | output | 1 | Pulse: a close changed the raw interrupt bits |
| eol_o | output | 1 | Halted at end of list |

## Verification
The assertions take the following for granted about the inputs:
- The memory returns a single-cycle acknowledge only while a request is pending, with read data valid in that cycle.
- Descriptors have an end field at or above their start.
- Descriptors never overlap their own buffers.

The stimulus memory model acknowledges after a random delay, and only a request it has not yet answered. The bench builds chains of non-overlapping descriptors and buffers, with a length of zero allowed. The stream source holds each byte until it is taken.

// File: rtl/strm_wr_pkg.sv
package strm_wr_pkg;
    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int LANE_W     = $clog2(LANES);
    localparam int IRQ_W      = 4;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    // control word bits
    localparam int F_LAST     = 0;
    localparam int F_IRQ      = 4;
    localparam int F_PKT_END  = 11;
    localparam int CTX_OFF    = 15;
    // word offsets of write-back fields
    localparam int OFS_CTRL   = 8;
    localparam int OFS_END    = 12;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_FILL, ST_FLUSH, ST_WB_FLAGS,
        ST_WB_END, ST_CTX_RD, ST_CTX_WR, ST_HALT
    } st_e;
endpackage

// File: rtl/strm_wr_pack.sv
module strm_wr_pack #(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    put_i,
    input  logic [$clog2(LANES)-1:0] lane_i,
    input  logic [7:0]              byte_i,
    input  logic                    clr_i,
    output logic [8*LANES-1:0]      word_o,
    output logic [LANES-1:0]        be_o
);
    localparam int LW = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] d_q;
        logic       v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr_i) begin
                v_q <= 1'b0;
            end else if (put_i && (lane_i == LW'(g))) begin
                d_q <= byte_i;
                v_q <= 1'b1;
            end
        end
        assign word_o[8*g +: 8] = d_q;
        assign be_o[g]          = v_q;
    end
endmodule

// File: rtl/strm_wr_irq.sv
module strm_wr_irq #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] raw_o,
    output logic         upd_o
);
    logic [W-1:0] raw_q, kept, add;
    logic         upd_q;

    assign kept = raw_q & ~ack_i;
    assign add  = set_en_i ? (set_i & ~kept) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            upd_q <= 1'b0;
        end else begin
            raw_q <= kept | add;
            upd_q <= |add;
        end
    end

    assign raw_o = raw_q;
    assign upd_o = upd_q;
endmodule

// File: rtl/strm_wr_dma.sv
module strm_wr_dma
    import strm_wr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] desc_i,
    input  logic [ADDR_W-1:0] ctx_i,
    input  logic              s_valid_i,
    input  logic [7:0]        s_data_i,
    input  logic              s_eop_i,
    output logic              s_ready_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic [3:0]        mem_be_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic [3:0]        irq_ack_i,
    output logic [3:0]        irq_raw_o,
    output logic              irq_upd_o,
    output logic              eol_o
);
    st_e st_q, st_d;

    logic [ADDR_W-1:0] desc_q, ctx_q, nxt_q, ptr_q, end_q, wadr_q;
    logic [WORD_W-1:0] flg_q, ctxw_q;
    logic [IDX_W-1:0]  idx_q;
    logic              closing_q, peop_q;
    logic              take, close, last, lane_full, pk_clr;
    logic [WORD_W-1:0] pk_word;
    logic [LANES-1:0]  pk_be;

    assign s_ready_o = (st_q == ST_FILL) && (ptr_q != end_q);
    assign take      = s_ready_o && s_valid_i;
    assign last      = ((ptr_q + ADDR_W'(1)) == end_q) || s_eop_i;
    assign lane_full = &ptr_q[LANE_W-1:0];
    assign pk_clr    = (st_q == ST_FLUSH) && mem_ack_i;
    assign eol_o     = (st_q == ST_HALT);

    strm_wr_pack #(.LANES(LANES)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .put_i  (take),
        .lane_i (ptr_q[LANE_W-1:0]),
        .byte_i (s_data_i),
        .clr_i  (pk_clr),
        .word_o (pk_word),
        .be_o   (pk_be)
    );

    strm_wr_irq #(.W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (close),
        .set_i    ({peop_q, 1'b0, flg_q[F_IRQ], flg_q[F_IRQ]}),
        .ack_i    (irq_ack_i),
        .raw_o    (irq_raw_o),
        .upd_o    (irq_upd_o)
    );

    // next state
    always_comb begin
        st_d  = st_q;
        close = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_HALT: if (start_i) st_d = ST_FETCH;
            ST_FETCH:    if (mem_ack_i && (idx_q == IDX_W'(DESC_WORDS - 1))) st_d = ST_FILL;
            ST_FILL: begin
                if (ptr_q == end_q) begin
                    st_d  = ST_WB_FLAGS;
                    close = 1'b1;
                end else if (take && (lane_full || last)) begin
                    st_d = ST_FLUSH;
                end
            end
            ST_FLUSH: if (mem_ack_i) begin
                st_d  = closing_q ? ST_WB_FLAGS : ST_FILL;
                close = closing_q;
            end
            ST_WB_FLAGS: if (mem_ack_i) st_d = ST_WB_END;
            ST_WB_END:   if (mem_ack_i) st_d = flg_q[F_LAST] ? ST_CTX_RD : ST_FETCH;
            ST_CTX_RD:   if (mem_ack_i) st_d = ST_CTX_WR;
            ST_CTX_WR:   if (mem_ack_i) st_d = ST_HALT;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // descriptor and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q    <= '0;
            ctx_q     <= '0;
            nxt_q     <= '0;
            ptr_q     <= '0;
            end_q     <= '0;
            wadr_q    <= '0;
            flg_q     <= '0;
            ctxw_q    <= '0;
            idx_q     <= '0;
            closing_q <= 1'b0;
            peop_q    <= 1'b0;
        end else begin
            if ((st_q == ST_IDLE || st_q == ST_HALT) && start_i) begin
                desc_q <= desc_i;
                ctx_q  <= ctx_i;
                idx_q  <= '0;
            end
            if (st_q == ST_FETCH && mem_ack_i) begin
                unique case (idx_q)
                    2'd0: nxt_q <= mem_rdata_i[ADDR_W-1:0];
                    2'd1: ptr_q <= mem_rdata_i[ADDR_W-1:0];
                    2'd2: flg_q <= mem_rdata_i;
                    default: begin
                        end_q     <= mem_rdata_i[ADDR_W-1:0];
                        closing_q <= 1'b0;
                        peop_q    <= 1'b0;
                    end
                endcase
                idx_q <= idx_q + 1'b1;
            end
            if (take) begin
                ptr_q     <= ptr_q + ADDR_W'(1);
                wadr_q    <= {ptr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                closing_q <= last;
                peop_q    <= s_eop_i;
            end
            if (st_q == ST_WB_END && mem_ack_i && !flg_q[F_LAST]) begin
                desc_q <= nxt_q;
                idx_q  <= '0;
            end
            if (st_q == ST_CTX_RD && mem_ack_i) ctxw_q <= mem_rdata_i;
        end
    end

    // bus outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = desc_q;
        mem_wdata_o = '0;
        mem_be_o    = '0;
        unique case (st_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + ADDR_W'({idx_q, 2'b00});
            end
            ST_FLUSH: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = wadr_q;
                mem_wdata_o = pk_word;
                mem_be_o    = pk_be;
            end
            ST_WB_FLAGS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + ADDR_W'(OFS_CTRL);
                mem_wdata_o = flg_q | (WORD_W'(peop_q) << F_PKT_END);
                mem_be_o    = '1;
            end
            ST_WB_END: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + ADDR_W'(OFS_END);
                mem_wdata_o = WORD_W'(ptr_q);
                mem_be_o    = '1;
            end
            ST_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctx_q;
            end
            ST_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_q;
                mem_wdata_o = ctxw_q | (WORD_W'(1) << CTX_OFF);
                mem_be_o    = '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/strm_wr_dma_chk.sv
module strm_wr_dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       s_ready_o,
    input logic       mem_req_o,
    input logic       mem_we_o,
    input logic [3:0] mem_be_o,
    input logic [3:0] irq_ack_i,
    input logic [3:0] irq_raw_o,
    input logic       irq_upd_o,
    input logic       eol_o
);
    // R2
    bus_blocks_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !s_ready_o);

    // R3
    write_has_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_be_o != 4'd0));

    // R8
    upd_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_upd_o |-> ((irq_raw_o & ~$past(irq_raw_o & ~irq_ack_i)) != 4'd0));

    // R7
    raw_rise_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_raw_o & ~$past(irq_raw_o)) != 4'd0) |-> irq_upd_o);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> (!mem_req_o && !s_ready_o));

    // R13
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_o && !start_i) |=> eol_o);
endmodule

bind strm_wr_dma strm_wr_dma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .s_ready_o (s_ready_o),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o),
    .mem_be_o  (mem_be_o),
    .irq_ack_i (irq_ack_i),
    .irq_raw_o (irq_raw_o),
    .irq_upd_o (irq_upd_o),
    .eol_o     (eol_o)
);

// File: tb/strm_wr_dma_test.sv
module strm_wr_dma_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] desc_i = '0, ctx_i = '0;
    logic        s_valid_i = 1'b0, s_eop_i = 1'b0;
    logic [7:0]  s_data_i = '0;
    logic        s_ready_o, mem_req_o, mem_we_o, mem_ack_i, irq_upd_o, eol_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0]  mem_be_o, irq_raw_o;
    logic [3:0]  irq_ack_i = '0;

    always #(CLK_P/2) clk = ~clk;

    strm_wr_dma #(.ADDR_W(32)) uut (.*);

    // memory model
    logic [7:0]  mem [0:1023];
    logic [7:0]  exp_m [0:1023];
    logic [31:0] rd_log [0:511];
    int          rd_cnt = 0;
    int          upd_tot = 0;
    logic        ack_q = 1'b0;
    logic [31:0] rdat_q = '0;
    logic [9:0]  ma;
    assign mem_ack_i   = ack_q;
    assign mem_rdata_i = rdat_q;

    always @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else begin
            ack_q <= 1'b0;
            if (mem_req_o && !ack_q && ($urandom % 3 != 0)) begin
                ack_q <= 1'b1;
                ma = mem_addr_o[9:0] & 10'h3FC;
                if (mem_we_o) begin
                    for (int j = 0; j < 4; j++)
                        if (mem_be_o[j]) mem[ma + 10'(j)] = mem_wdata_o[8*j +: 8];
                end else begin
                    rdat_q <= {mem[ma+3], mem[ma+2], mem[ma+1], mem[ma]};
                    if (rd_cnt < 512) rd_log[rd_cnt] = mem_addr_o;
                    rd_cnt = rd_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) if (rst_n && irq_upd_o) upd_tot = upd_tot + 1;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int j = 0; j < 4; j++) mem[a + j] = v[8*j +: 8];
    endtask

    function automatic logic [31:0] get32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    // chain description
    int          nd;
    int          da [0:7];
    int          db [0:7];
    int          de [0:7];
    logic [31:0] df [0:7];
    int          ea [0:7];
    logic [7:0]  src_b [0:255];
    bit          src_e [0:255];
    int          n_src, n_acc, k_exp, upd_exp;
    logic [3:0]  raw_m = '0;
    logic [31:0] ctxv;

    // expected result from the requirements
    task automatic model();
        int k = 0;
        logic [3:0] set;
        for (int a = 0; a < 1024; a++) exp_m[a] = mem[a];
        upd_exp = 0;
        for (int d = 0; d < nd; d++) begin
            int p = db[d];
            bit ce = 1'b0;
            while (p != de[d] && !ce) begin
                exp_m[p] = src_b[k];
                ce = src_e[k];
                p++;
                k++;
            end
            ea[d] = p;
            for (int j = 0; j < 4; j++) begin
                exp_m[da[d]+8+j]  = 8'((df[d] | (32'(ce) << 11)) >> (8*j));
                exp_m[da[d]+12+j] = 8'(32'(p) >> (8*j));
            end
            set = {ce, 1'b0, df[d][4], df[d][4]};
            if ((set & ~raw_m) != 0) upd_exp++;
            raw_m = raw_m | set;
        end
        for (int j = 0; j < 4; j++) exp_m[12'h3F0 + j] = 8'((ctxv | 32'h8000) >> (8*j));
        k_exp = k;
    endtask

    task automatic run_round(input bit poke);
        int i = 0;
        int u0;
        int bad = 0;
        for (int d = 0; d < nd; d++) begin
            put32(da[d], (d == nd-1) ? 32'h0 : 32'(da[d+1]));
            put32(da[d]+4, 32'(db[d]));
            put32(da[d]+8, df[d]);
            put32(da[d]+12, 32'(de[d]));
        end
        put32(12'h3F0, ctxv);
        model();
        u0 = upd_tot;
        @(negedge clk);
        start_i = 1'b1; desc_i = 32'(da[0]); ctx_i = 32'h3F0;
        @(negedge clk);
        start_i = 1'b0;
        chk(!eol_o, "R13 restart clears eol", 32'(eol_o), 0);
        while (i < n_src && !eol_o) begin
            bit hs;
            s_valid_i = 1'b1; s_data_i = src_b[i]; s_eop_i = src_e[i];
            if (poke && i == 3) begin
                start_i = 1'b1; desc_i = 32'h0F0;
            end else start_i = 1'b0;
            hs = s_ready_o;
            @(negedge clk);
            if (hs) i++;
        end
        start_i = 1'b0;
        while (!eol_o) @(negedge clk);
        n_acc = i;
        // R11: pending byte stays refused
        for (int c = 0; c < 20; c++) begin
            if (s_ready_o) bad++;
            @(negedge clk);
        end
        s_valid_i = 1'b0; s_eop_i = 1'b0;
        chk(bad == 0, "R11 ready low after end of list", 32'(bad), 0);
        chk(n_acc == k_exp, "R4 bytes taken", 32'(n_acc), 32'(k_exp));
        bad = 0;
        for (int a = 0; a < 1024; a++) if (mem[a] !== exp_m[a]) bad++;
        chk(bad == 0, "R3 R5 R6 R10 memory image", 32'(bad), 0);
        for (int d = 0; d < nd; d++)
            chk(get32(da[d]+12) == 32'(ea[d]), "R5 written-back end", get32(da[d]+12), 32'(ea[d]));
        chk(get32(12'h3F0) == (ctxv | 32'h8000), "R11 context disabled", get32(12'h3F0), ctxv | 32'h8000);
        chk(irq_raw_o == raw_m, "R7 raw interrupts", 32'(irq_raw_o), 32'(raw_m));
        chk(upd_tot - u0 == upd_exp, "R8 update pulses", 32'(upd_tot - u0), 32'(upd_exp));
    endtask

    task automatic ack_irq(input logic [3:0] m);
        @(negedge clk); irq_ack_i = m;
        @(negedge clk); irq_ack_i = '0;
        raw_m = raw_m & ~m;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < 1024; a++) mem[a] = 8'(a * 7 + 3);
        repeat (3) @(negedge clk);
        // R1
        chk(!s_ready_o, "R1 ready", 32'(s_ready_o), 0);
        chk(!mem_req_o, "R1 req", 32'(mem_req_o), 0);
        chk(irq_raw_o == 0 && !irq_upd_o, "R1 irq", 32'(irq_raw_o), 0);
        chk(!eol_o, "R1 eol", 32'(eol_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_ready_o && !mem_req_o, "R1 idle after reset", 32'({s_ready_o, mem_req_o}), 0);

        // directed chain: unaligned buffer, empty buffer (R12), early packet end
        nd = 3;
        da[0] = 12'h040; db[0] = 12'h101; de[0] = 12'h10A; df[0] = 32'h10;
        da[1] = 12'h060; db[1] = 12'h200; de[1] = 12'h200; df[1] = 32'h10;
        da[2] = 12'h020; db[2] = 12'h302; de[2] = 12'h320; df[2] = 32'h11;
        ctxv = 32'h0000_1234;
        n_src = 14;
        for (int i = 0; i < 14; i++) begin
            src_b[i] = 8'hA0 + 8'(i); src_e[i] = (i == 11);
        end
        run_round(1'b0);
        // R2 fetch order
        for (int j = 0; j < 4; j++)
            chk(rd_log[j] == 32'h40 + 32'(4*j), "R2 fetch order", rd_log[j], 32'h40 + 32'(4*j));
        chk(rd_log[4] == 32'h60, "R10 link followed", rd_log[4], 32'h60);
        chk(get32(12'h06C) == 32'h200 && get32(12'h068) == 32'h10, "R12 empty buffer",
            get32(12'h068), 32'h10);
        chk(get32(12'h028) == 32'h811, "R5 packet-end flag", get32(12'h028), 32'h811);
        chk(get32(12'h04C) == 32'h10A, "R4 full close end", get32(12'h04C), 32'h10A);
        chk(mem[12'h100] == 8'(12'h100 * 7 + 3), "R3 untouched lane", 32'(mem[12'h100]), 32'(8'(12'h100*7+3)));
        chk(irq_raw_o == 4'hB, "R7 raw value", 32'(irq_raw_o), 32'hB);
        // R9
        ack_irq(4'h1);
        chk(irq_raw_o == 4'hA, "R9 partial ack", 32'(irq_raw_o), 32'hA);
        ack_irq(4'hF);
        chk(irq_raw_o == 4'h0, "R9 full ack", 32'(irq_raw_o), 0);

        // random chains
        for (int r = 0; r < 4; r++) begin
            int cap = 0;
            nd = 3 + int'($urandom % 4);
            for (int d = 0; d < nd; d++) begin
                da[d] = 16 * ((d * 3 + r) % 8);
                db[d] = 12'h100 + d * 12'h40 + int'($urandom % 4);
                de[d] = db[d] + int'($urandom % 25);
                df[d] = (32'($urandom % 2) << 4) | (32'($urandom % 2) << 8) | 32'(d == nd-1);
                cap += de[d] - db[d];
            end
            ctxv = $urandom & 32'hFFFF_7FFF;
            n_src = cap + 6;
            for (int i = 0; i < n_src; i++) begin
                src_b[i] = 8'($urandom); src_e[i] = ($urandom % 6 == 0);
            end
            run_round(r == 1);
            if (r == 2) begin
                ack_irq(4'hF);
                chk(irq_raw_o == 4'h0, "R9 ack between chains", 32'(irq_raw_o), 0);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule